// File: doc/BRIEF.md
# Discrete Cartridge Bank Mapper

This block is the address translator of a game cartridge whose banking logic is built from plain registers and multiplexers. The CPU programs it by writing into a small register window in the upper half of its address space. From those registers the block turns each CPU and PPU address into a program bank number, a character bank number, ROM and RAM selects, and the nametable RAM address line that sets the mirroring arrangement.

Program space is split into four 8 KB windows and character space into eight 1 KB windows; every window has its own bank register. Two program windows can reach either of the two 128 KB program ROMs, while the other two always reach the second ROM. The output bank number treats both ROMs as one 256 KB space whose top bit selects the chip. Only the address and data lines the logic actually uses are brought in: CPU A15-A13 and A3-A0, data D6-D0 and PPU A13-A10. Bank registers are not cleared by reset; software must load them before use.

Top module: `cart_bank_xlat`

## Requirements
- R1: A register is written at the rising `clk` edge where `cpu_m2` is seen low after being high in the previous edge, with `cpu_rw`=0 and `cpu_a_hi[2]`=1; `cpu_a_lo` picks the register and `cpu_a_hi[1:0]` do not matter. Holding `cpu_m2` high writes nothing.
- R2: Reads (`cpu_rw`=1) and writes with `cpu_a_hi[2]`=0 change no register.
- R3: `chr_bank` is the register numbered `ppu_a_hi[2:0]` (PPU A12-A10), 7 bits wide.
- R4: Registers 0 and 2 store written D6-D1 with bit 0 forced to 0; registers 1 and 3 force bit 0 to 1.
- R5: Registers 4-7 store all of D6-D0.
- R6: For CPU A14-A13 = 00 or 11 (registers 8 and 11), `prg_bank` = {1, D3-D0 as written}; D6-D4 are ignored.
- R7: For CPU A14-A13 = 01 or 10 (registers 9 and 10), `prg_bank` = D4-D0 as written.
- R8: `prg_rom_sel` is 2'b10 when `prg_bank[4]`=1 and 2'b01 when it is 0, only for a CPU read with A15=1; otherwise 2'b00.
- R9: `prg_ram_sel` is 1 exactly when CPU A15-A13 = 011, for reads and writes.
- R10: Register 12 bit 0 sets mirroring: 0 drives `ciram_a10` from PPU A10, 1 from PPU A11.
- R11: `chr_rom_sel` is 1 exactly when PPU A13 = 0.
- R12: Writes to registers 13, 14 and 15 change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, faster than M2 |
| rst_n | input | 1 | Active-low reset of the M2 edge detector |
| cpu_a_hi | input | 3 | CPU A15-A13 |
| cpu_a_lo | input | 4 | CPU A3-A0 |
| cpu_data | input | 7 | CPU D6-D0 |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| cpu_m2 | input | 1 | CPU M2 phase |
| ppu_a_hi | input | 4 | PPU A13-A10 |
| prg_bank | output | 5 | 8 KB bank in the joint 256 KB program space |
| prg_rom_sel | output | 2 | One-hot program ROM chip select |
| prg_ram_sel | output | 1 | Program RAM select |
| chr_bank | output | 7 | 1 KB character bank |
| chr_rom_sel | output | 1 | Character ROM select |
| ciram_a10 | output | 1 | Nametable RAM A10 |

## Verification
After loading all registers with values whose bit 7, bit 0 and bit 4 differ from what the mapping keeps, the translation is tried at the first and last byte and at interior addresses of every program and character window, so a swapped window, a lost forced bit or a dropped ROM-select bit each give a distinct wrong bank. Writes through aliased addresses show that only A3-A0 and A15 decode. Reads, low-half writes, an M2 held high and writes to the three spare registers are each followed by a full re-check, which separates a leaky write strobe from a correct one. Both mirroring settings are tried with PPU addresses where A10 and A11 differ.

// File: rtl/cbx_pkg.sv
package cbx_pkg;
    localparam int CHR_W   = 7;
    localparam int PRG_W   = 5;
    localparam int NUM_CHR = 8;
    localparam int NUM_PRG = 4;
    localparam int REG_AW  = 4;
    localparam int FORCED_CHR = 4;   // low slots whose bank bit 0 is fixed
    localparam logic [REG_AW-1:0] MIRR_IDX = 4'd12;
    localparam logic [REG_AW-1:0] PRG_BASE = 4'd8;

    typedef logic [NUM_CHR-1:0][CHR_W-1:0] chr_file_t;
    typedef logic [NUM_PRG-1:0][PRG_W-1:0] prg_file_t;
endpackage

// File: rtl/cbx_regfile.sv
module cbx_regfile
    import cbx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_a15,
    input  logic [REG_AW-1:0] cpu_a_lo,
    input  logic [CHR_W-1:0]  cpu_data,
    input  logic              cpu_rw,
    input  logic              cpu_m2,
    output chr_file_t         chr_regs,
    output prg_file_t         prg_regs,
    output logic              mirr_h
);
    typedef struct packed {
        chr_file_t chr;
        prg_file_t prg;
        logic      mirr;
        logic      m2;
    } rf_t;

    rf_t  st_d, st_q;
    logic wr_stb;

    always_comb begin
        st_d    = st_q;
        st_d.m2 = cpu_m2;
        wr_stb  = st_q.m2 & ~cpu_m2 & ~cpu_rw & cpu_a15;
        if (wr_stb) begin
            for (int i = 0; i < NUM_CHR; i++) begin
                if (cpu_a_lo == REG_AW'(i)) begin
                    if (i < FORCED_CHR)
                        st_d.chr[i] = {cpu_data[CHR_W-1:1], (i % 2) == 1};
                    else
                        st_d.chr[i] = cpu_data;
                end
            end
            for (int j = 0; j < NUM_PRG; j++) begin
                if (cpu_a_lo == PRG_BASE + REG_AW'(j)) begin
                    if (j == 0 || j == NUM_PRG - 1)
                        st_d.prg[j] = {1'b1, cpu_data[PRG_W-2:0]};
                    else
                        st_d.prg[j] = cpu_data[PRG_W-1:0];
                end
            end
            if (cpu_a_lo == MIRR_IDX)
                st_d.mirr = cpu_data[0];
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
        if (!rst_n)
            st_q.m2 <= 1'b0;
    end

    assign chr_regs = st_q.chr;
    assign prg_regs = st_q.prg;
    assign mirr_h   = st_q.mirr;

    // R4
    chr0_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.m2 && !cpu_m2 && !cpu_rw && cpu_a15 && cpu_a_lo == 4'd0)
        |=> (st_q.chr[0] == {$past(cpu_data[CHR_W-1:1]), 1'b0}));

    // R2
    mirr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rw || !cpu_a15) |=> $stable(st_q.mirr));

    // R1
    m2_high_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.m2 && cpu_m2) |=> ($stable(st_q.chr) && $stable(st_q.prg)));
endmodule

// File: rtl/cbx_prg_map.sv
module cbx_prg_map
    import cbx_pkg::*;
(
    input  logic [2:0]       cpu_a_hi,
    input  logic             cpu_rw,
    input  prg_file_t        prg_regs,
    output logic [PRG_W-1:0] prg_bank,
    output logic [1:0]       prg_rom_sel,
    output logic             prg_ram_sel
);
    always_comb begin
        prg_bank    = prg_regs[cpu_a_hi[1:0]];
        prg_rom_sel = 2'b00;
        if (cpu_a_hi[2] && cpu_rw)
            prg_rom_sel = prg_bank[PRG_W-1] ? 2'b10 : 2'b01;
        prg_ram_sel = (cpu_a_hi == 3'b011);
    end
endmodule

// File: rtl/cbx_chr_map.sv
module cbx_chr_map
    import cbx_pkg::*;
(
    input  logic [3:0]       ppu_a_hi,
    input  chr_file_t        chr_regs,
    input  logic             mirr_h,
    output logic [CHR_W-1:0] chr_bank,
    output logic             chr_rom_sel,
    output logic             ciram_a10
);
    always_comb begin
        chr_bank    = chr_regs[ppu_a_hi[2:0]];
        chr_rom_sel = ~ppu_a_hi[3];
        ciram_a10   = mirr_h ? ppu_a_hi[1] : ppu_a_hi[0];
    end
endmodule

// File: rtl/cart_bank_xlat.sv
module cart_bank_xlat
    import cbx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       cpu_a_hi,
    input  logic [3:0]       cpu_a_lo,
    input  logic [6:0]       cpu_data,
    input  logic             cpu_rw,
    input  logic             cpu_m2,
    input  logic [3:0]       ppu_a_hi,
    output logic [4:0]       prg_bank,
    output logic [1:0]       prg_rom_sel,
    output logic             prg_ram_sel,
    output logic [6:0]       chr_bank,
    output logic             chr_rom_sel,
    output logic             ciram_a10
);
    chr_file_t chr_regs;
    prg_file_t prg_regs;
    logic      mirr_h;

    cbx_regfile u_rf (
        .clk      (clk),
        .rst_n    (rst_n),
        .cpu_a15  (cpu_a_hi[2]),
        .cpu_a_lo (cpu_a_lo),
        .cpu_data (cpu_data),
        .cpu_rw   (cpu_rw),
        .cpu_m2   (cpu_m2),
        .chr_regs (chr_regs),
        .prg_regs (prg_regs),
        .mirr_h   (mirr_h)
    );

    cbx_prg_map u_prg (
        .cpu_a_hi    (cpu_a_hi),
        .cpu_rw      (cpu_rw),
        .prg_regs    (prg_regs),
        .prg_bank    (prg_bank),
        .prg_rom_sel (prg_rom_sel),
        .prg_ram_sel (prg_ram_sel)
    );

    cbx_chr_map u_chr (
        .ppu_a_hi    (ppu_a_hi),
        .chr_regs    (chr_regs),
        .mirr_h      (mirr_h),
        .chr_bank    (chr_bank),
        .chr_rom_sel (chr_rom_sel),
        .ciram_a10   (ciram_a10)
    );

    // R6
    win3_second_rom_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_a_hi == 3'b111 && cpu_rw) |-> (prg_bank[4] && prg_rom_sel == 2'b10));

    // R4
    chr_slot1_odd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ppu_a_hi[2:0] == 3'd1) |-> chr_bank[0]);

    // R9
    ram_rom_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prg_ram_sel |-> (prg_rom_sel == 2'b00));
endmodule

// File: tb/sim_cart_bank_xlat.sv
`timescale 1ns/1ps
module sim_cart_bank_xlat;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] cpu_a_hi = 3'b000;
    logic [3:0] cpu_a_lo = 4'h0;
    logic [6:0] cpu_data = 7'h00;
    logic       cpu_rw = 1'b1;
    logic       cpu_m2 = 1'b0;
    logic [3:0] ppu_a_hi = 4'h0;
    logic [4:0] prg_bank;
    logic [1:0] prg_rom_sel;
    logic       prg_ram_sel;
    logic [6:0] chr_bank;
    logic       chr_rom_sel;
    logic       ciram_a10;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    cart_bank_xlat u0 (.*);

    // {cpu A15-A13, ppu A13-A10, expected prg_bank, expected chr_bank}
    localparam logic [18:0] VEC [8] = '{
        {3'b100, 4'h0, 5'h13, 7'h7E},
        {3'b101, 4'h1, 5'h0A, 7'h01},
        {3'b110, 4'h2, 5'h1C, 7'h12},
        {3'b111, 4'h3, 5'h10, 7'h2B},
        {3'b100, 4'h4, 5'h13, 7'h55},
        {3'b101, 4'h5, 5'h0A, 7'h2A},
        {3'b110, 4'h6, 5'h1C, 7'h01},
        {3'b111, 4'h7, 5'h10, 7'h7E}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    // full 8-bit value; bit 7 has no pin and is dropped here
    task automatic wr(input logic [2:0] hi, input logic [3:0] idx, input logic [7:0] d);
        cpu_a_hi = hi; cpu_a_lo = idx; cpu_data = d[6:0]; cpu_rw = 1'b0; cpu_m2 = 1'b1;
        @(posedge clk); #1;
        cpu_m2 = 1'b0;
        @(posedge clk); #1;
        cpu_rw = 1'b1;
    endtask

    task automatic walk(input string tag);
        for (int v = 0; v < 8; v++) begin
            cpu_a_hi = VEC[v][18:16];
            ppu_a_hi = VEC[v][15:12];
            cpu_rw   = 1'b1;
            @(negedge clk);
            chk({tag, " R3 R5 chr"}, chr_bank, VEC[v][6:0]);
            chk({tag, " R6 R7 prg"}, prg_bank, VEC[v][11:7]);
            chk({tag, " R8 sel"}, prg_rom_sel, VEC[v][11] ? 2 : 1);
            chk({tag, " R11 chr sel"}, chr_rom_sel, 1);
        end
    endtask

    initial begin
        fork
            begin
                #200000;
                n_bad++;
                $display("FAIL watchdog: got timeout expected completion");
            end
            begin
                repeat (3) @(posedge clk);
                #1 rst_n = 1'b1;
                @(negedge clk);
                chk("reset R8 rom sel", prg_rom_sel, 0);
                chk("reset R9 ram sel", prg_ram_sel, 0);
                chk("reset R11 chr sel", chr_rom_sel, 1);

                wr(3'b100, 4'd0,  8'hFF);   // R4 -> 7E
                wr(3'b101, 4'd1,  8'h80);   // R4 -> 01
                wr(3'b100, 4'd2,  8'h13);   // -> 12
                wr(3'b110, 4'd3,  8'h2A);   // -> 2B
                wr(3'b111, 4'd4,  8'h55);   // R1 alias
                wr(3'b100, 4'd5,  8'hAA);   // -> 2A
                wr(3'b100, 4'd6,  8'h01);
                wr(3'b100, 4'd7,  8'hFE);
                wr(3'b100, 4'd8,  8'hF3);   // R6 -> 13
                wr(3'b100, 4'd9,  8'h0A);   // R7 first ROM
                wr(3'b111, 4'd10, 8'h1C);   // R7 alias
                wr(3'b100, 4'd11, 8'h00);   // R6 -> 10
                wr(3'b100, 4'd12, 8'hFE);   // R10 vertical
                walk("R1 table");

                // R2: read cycle and low-half write
                cpu_a_hi = 3'b100; cpu_a_lo = 4'd8; cpu_data = 7'h00; cpu_rw = 1'b1; cpu_m2 = 1'b1;
                @(posedge clk); #1 cpu_m2 = 1'b0; @(posedge clk); #1;
                wr(3'b000, 4'd8, 8'h00);
                wr(3'b011, 4'd0, 8'h00);
                walk("R2 after reads");

                // R1: M2 held high, no fall, no latch
                cpu_a_hi = 3'b100; cpu_a_lo = 4'd9; cpu_data = 7'h1F; cpu_rw = 1'b0; cpu_m2 = 1'b1;
                repeat (4) @(posedge clk);
                #1 cpu_rw = 1'b1; cpu_m2 = 1'b0;
                walk("R1 m2 high");

                // R12
                wr(3'b100, 4'd13, 8'hFF);
                wr(3'b100, 4'd14, 8'hFF);
                wr(3'b100, 4'd15, 8'hFF);
                walk("R12 spare");

                // R10 vertical
                ppu_a_hi = 4'b1001; @(negedge clk);
                chk("R10 vert A10=1", ciram_a10, 1);
                ppu_a_hi = 4'b1010; @(negedge clk);
                chk("R10 vert A11=1", ciram_a10, 0);
                chk("R11 ppu A13 high", chr_rom_sel, 0);
                wr(3'b100, 4'd12, 8'h01);
                ppu_a_hi = 4'b1001; @(negedge clk);
                chk("R10 horiz A10=1", ciram_a10, 0);
                ppu_a_hi = 4'b1010; @(negedge clk);
                chk("R10 horiz A11=1", ciram_a10, 1);

                // R9 / R8
                cpu_a_hi = 3'b011; cpu_rw = 1'b0; @(negedge clk);
                chk("R9 ram write", prg_ram_sel, 1);
                chk("R8 no rom on ram", prg_rom_sel, 0);
                cpu_rw = 1'b1; @(negedge clk);
                chk("R9 ram read", prg_ram_sel, 1);
                cpu_a_hi = 3'b010; @(negedge clk);
                chk("R9 below ram", prg_ram_sel, 0);
                chk("R8 low half", prg_rom_sel, 0);
                cpu_a_hi = 3'b101; cpu_rw = 1'b0; @(negedge clk);
                chk("R8 rom write", prg_rom_sel, 0);
                chk("R9 rom area", prg_ram_sel, 0);
                cpu_rw = 1'b1;
            end
        join_any
        disable fork;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule